// File: doc/BRIEF.md
# Programmable Master Trigger Generator

The block produces the system master trigger from one of three sources. The first is a register bit that software writes. The second is an external trigger line. The third is an internal repeating timer. A programmable divider turns the fast clock into a slow tick enable. The timer counts those ticks with a 16-bit reload register and fires once each time the count runs out.

The chosen source becomes a one-cycle trigger strobe for the logic on the chip. The same event also drives the trigger output pin. That pin is stretched over a fixed number of fast cycles so that a receiver off the chip can see it.

No data flows through this block: every pin is a plain control or status signal, so the block has no valid/ready handshake and no back-pressure.

Top module: `tmg_master_trigger`

## Requirements
- R1: While `rst_n` is low, `trig_strobe` and `trig_pin` are 0.
- R2: `src_sel` picks the source: 0 is the software bit, 1 is the external line, 2 is the timer, and 3 selects nothing. A source that is not selected never causes a strobe.
- R3: A one-cycle `sw_trig_wr` pulse sampled at clock edge k sets the self-clearing software bit. `trig_strobe` is then high for exactly one cycle, after edge k+1.
- R4: `ext_trig_in` passes through a two-flop synchronizer. A rising level first sampled at edge k gives one strobe cycle after edge k+2. Holding the line high gives no further strobes.
- R5: The slow tick enable fires once every `div_val`+1 fast cycles.
- R6: With the timer selected, strobes repeat every `per_val` slow ticks, that is every (`div_val`+1)·`per_val` fast cycles.
- R7: A `per_val` of 0 means 65536 ticks. With `div_val`=0, the first strobe comes 65536 cycles after the timer is selected.
- R8: A change to `per_val` has no effect on the period already running. It takes effect at the next reload.
- R9: `trig_pin` goes high in the same cycle as each strobe and stays high for PIN_CYC (4) cycles. A new strobe restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 2 | Source select: 0 software, 1 external, 2 timer, 3 none |
| div_val | input | 8 | Slow tick divider; the tick period is div_val+1 fast cycles |
| per_val | input | 16 | Timer period in slow ticks; 0 means 65536 |
| sw_trig_wr | input | 1 | Write strobe that sets the software trigger bit |
| ext_trig_in | input | 1 | External trigger line, asynchronous |
| trig_strobe | output | 1 | One-cycle master trigger strobe |
| trig_pin | output | 1 | Stretched trigger for the output pin |

## Verification
The bench sweeps the divider from 0 to 3 and the period from 1 to 6, and it times the gap between strobes against (div+1)·period. An off-by-one in the reload or in the divider compare would show up as a gap one tick or one cycle too long. A design that used 0 as a real zero period would fire at once or never, where it should wait exactly 65536 cycles. It checks that a period change made in the middle of a count leaves the period already running unchanged. It also checks the exact latency of the software and external paths, and whether an unselected source can leak through to the strobe. A synchronizer that was level-based instead of edge-based would repeat strobes while the line stays high.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_EXT = 2'd1,
    SRC_TMR = 2'd2,
    SRC_OFF = 2'd3
  } trig_src_e;
endpackage

// File: rtl/tmg_tick_div.sv
module tmg_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             slow_tick
);
  logic [DIV_W-1:0] dcnt;

  // >= keeps the counter from running past a newly lowered limit
  assign slow_tick = (dcnt >= div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dcnt <= '0;
    else if (slow_tick) dcnt <= '0;
    else                dcnt <= dcnt + 1'b1;
  end
endmodule

// File: rtl/tmg_period_timer.sv
module tmg_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             slow_tick,
  input  logic [PER_W-1:0] per_val,
  output logic             expire
);
  logic [PER_W-1:0] tcnt;
  logic [PER_W-1:0] reload;

  // a zero period wraps to all ones, giving 2**PER_W ticks
  assign reload = per_val - 1'b1;
  assign expire = enable && slow_tick && (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tcnt <= '1;
    else if (!enable)    tcnt <= reload;
    else if (slow_tick) begin
      if (tcnt == '0)    tcnt <= reload;
      else               tcnt <= tcnt - 1'b1;
    end
  end
endmodule

// File: rtl/tmg_edge_sync.sv
module tmg_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[SYNC_STAGES-1];
  end

  assign rise_pulse = chain[SYNC_STAGES-1] & ~prev;
endmodule

// File: rtl/tmg_master_trigger.sv
module tmg_master_trigger #(
  parameter int DIV_W       = 8,
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PIN_CYC     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic [PER_W-1:0] per_val,
  input  logic             sw_trig_wr,
  input  logic             ext_trig_in,
  output logic             trig_strobe,
  output logic             trig_pin
);
  import tmg_pkg::*;

  localparam int PIN_W = $clog2(PIN_CYC + 1);

  trig_src_e        src;
  logic             slow_tick;
  logic             tmr_expire;
  logic             ext_rise;
  logic             sw_bit;
  logic             fire;
  logic [PIN_W-1:0] pin_cnt;

  assign src = trig_src_e'(src_sel);

  tmg_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .slow_tick(slow_tick)
  );

  tmg_period_timer #(.PER_W(PER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .enable(src == SRC_TMR),
    .slow_tick(slow_tick), .per_val(per_val), .expire(tmr_expire)
  );

  tmg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trig_in), .rise_pulse(ext_rise)
  );

  // software bit: set by a write, cleared on the following cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_bit <= 1'b0;
    else        sw_bit <= sw_trig_wr & ~sw_bit;
  end

  always_comb begin
    case (src)
      SRC_SW:  fire = sw_bit;
      SRC_EXT: fire = ext_rise;
      SRC_TMR: fire = tmr_expire;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_strobe <= 1'b0;
      pin_cnt     <= '0;
    end else begin
      trig_strobe <= fire;
      if (fire)                pin_cnt <= PIN_W'(PIN_CYC);
      else if (pin_cnt != '0)  pin_cnt <= pin_cnt - 1'b1;
    end
  end

  assign trig_pin = (pin_cnt != '0);
endmodule

// File: rtl/tmg_checker.sv
module tmg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src_sel,
  input logic       sw_trig_wr,
  input logic       ext_trig_in,
  input logic       trig_strobe,
  input logic       trig_pin
);
  import tmg_pkg::*;

  assert_pin_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe |-> trig_pin);

  assert_pin_no_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_pin) |-> !trig_strobe);

  assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == SRC_OFF) |-> !trig_strobe);

  assert_sw_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_strobe && $past(src_sel) == SRC_SW) |-> $past(sw_trig_wr, 2));

  assert_sw_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_strobe && $past(src_sel) == SRC_SW && src_sel == SRC_SW) |=> !trig_strobe);

  assert_ext_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_strobe && $past(src_sel) == SRC_EXT) |-> $past(ext_trig_in, 3));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!trig_strobe);
    end
  end
endmodule

bind tmg_master_trigger tmg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_trig_wr(sw_trig_wr),
  .ext_trig_in(ext_trig_in), .trig_strobe(trig_strobe), .trig_pin(trig_pin)
);

// File: tb/tb_tmg_master_trigger.sv
module tb_tmg_master_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'd3;
  logic [7:0]  div_val = '0;
  logic [15:0] per_val = 16'd1;
  logic        sw_trig_wr = 1'b0;
  logic        ext_trig_in = 1'b0;
  logic        trig_strobe;
  logic        trig_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmg_master_trigger dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_val(div_val),
    .per_val(per_val), .sw_trig_wr(sw_trig_wr), .ext_trig_in(ext_trig_in),
    .trig_strobe(trig_strobe), .trig_pin(trig_pin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge and sample just after it
  task automatic step();
    @(posedge clk); #1;
  endtask

  // drive at the falling edge
  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic wait_strobe(input int limit, output int n);
    n = 0;
    do begin step(); n++; end while (!trig_strobe && n < limit);
  endtask

  task automatic count_strobes(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin step(); if (trig_strobe) cnt++; end
  endtask

  task automatic measure(input int dv, input int pv);
    int n;
    at_neg(); src_sel = 2'd3; div_val = 8'(dv); per_val = 16'(pv);
    repeat (2) step();
    at_neg(); src_sel = 2'd2;
    wait_strobe(200, n);
    wait_strobe(200, n);
    if (pv == 1) chk(n == dv + 1, "R5 tick period", n, dv + 1);
    else         chk(n == (dv + 1) * pv, "R6 timer period", n, (dv + 1) * pv);
  endtask

  initial begin
    int n, cnt, hi;
    // R1 reset state
    repeat (3) step();
    chk(trig_strobe == 0, "R1 strobe in reset", trig_strobe, 0);
    chk(trig_pin == 0, "R1 pin in reset", trig_pin, 0);
    at_neg(); rst_n = 1'b1;
    step();

    // R3 software path latency and single strobe
    at_neg(); src_sel = 2'd0; sw_trig_wr = 1'b1;
    at_neg(); sw_trig_wr = 1'b0;
    #1;
    chk(trig_strobe == 0, "R3 not yet", trig_strobe, 0);
    step();
    chk(trig_strobe == 1, "R3 strobe after k+1", trig_strobe, 1);
    // R9 pin stretch
    hi = 1;
    for (int i = 0; i < 8; i++) begin step(); if (trig_pin) hi++; end
    chk(hi == 4, "R9 pin width", hi, 4);
    count_strobes(10, cnt);
    chk(cnt == 0, "R3 self clear", cnt, 0);

    // R4 external path latency
    at_neg(); src_sel = 2'd1; ext_trig_in = 1'b1;
    step(); chk(trig_strobe == 0, "R4 sample1", trig_strobe, 0);
    step(); chk(trig_strobe == 0, "R4 sample2", trig_strobe, 0);
    step(); chk(trig_strobe == 1, "R4 strobe after k+2", trig_strobe, 1);
    count_strobes(12, cnt);
    chk(cnt == 0, "R4 held high no repeat", cnt, 0);
    at_neg(); ext_trig_in = 1'b0;
    repeat (4) step();

    // R2 isolation: sw selected, ext edge and timer ignored
    at_neg(); src_sel = 2'd0; div_val = '0; per_val = 16'd1; ext_trig_in = 1'b1;
    count_strobes(20, cnt);
    chk(cnt == 0, "R2 ext ignored under sw", cnt, 0);
    at_neg(); ext_trig_in = 1'b0; src_sel = 2'd1; sw_trig_wr = 1'b1;
    at_neg(); sw_trig_wr = 1'b0;
    count_strobes(20, cnt);
    chk(cnt == 0, "R2 sw ignored under ext", cnt, 0);
    at_neg(); src_sel = 2'd3; sw_trig_wr = 1'b1; ext_trig_in = 1'b1;
    at_neg(); sw_trig_wr = 1'b0;
    count_strobes(20, cnt);
    chk(cnt == 0, "R2 nothing under none", cnt, 0);
    at_neg(); ext_trig_in = 1'b0;
    repeat (4) step();

    // R5/R6 sweep
    for (int d = 0; d < 4; d++)
      for (int p = 1; p < 7; p++) measure(d, p);

    // R9 retrigger: period 2 keeps pin high
    at_neg(); src_sel = 2'd3; div_val = '0; per_val = 16'd2;
    step(); at_neg(); src_sel = 2'd2;
    wait_strobe(50, n);
    hi = 0;
    for (int i = 0; i < 20; i++) begin step(); if (trig_pin) hi++; end
    chk(hi == 20, "R9 retrigger keeps pin", hi, 20);

    // R8 period change applies at next reload
    at_neg(); src_sel = 2'd3; per_val = 16'd10;
    step(); at_neg(); src_sel = 2'd2;
    wait_strobe(50, n);
    repeat (3) step();
    at_neg(); per_val = 16'd3;
    wait_strobe(50, n);
    chk(n == 7, "R8 running period kept", n + 3, 10);
    wait_strobe(50, n);
    chk(n == 3, "R8 new period", n, 3);

    // R7 zero period
    at_neg(); src_sel = 2'd3; per_val = 16'd0;
    step(); at_neg(); src_sel = 2'd2;
    wait_strobe(70000, n);
    chk(n == 65536, "R7 zero means 65536", n, 65536);
    at_neg(); src_sel = 2'd3;
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule